// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host on a narrow byte-wide I/O bus access to a bank of 8-bit configuration registers through only two bus addresses. One address holds a register selector, the other carries data. The host first writes the number of the register it wants to the selector address, then makes exactly one read or write on the data address. That data access uses up the selector. The next data access needs a new selector write.

A control register is always reachable. Bit 4 of that register is an unlock flag. While the flag is clear, the group of extended registers stays sealed: reads of it return all ones and writes to it are discarded. Software unlocks the group with a save, set, access and restore sequence on the control register.

One extended register holds a 2-bit field. The block turns that field into the base address of a memory-mapped register window and drives the base on an output.

The bus uses plain strobes. A read strobe returns data combinationally in the same cycle, and the block never stalls the bus, so there is no back-pressure.

Top module: `cfg_index_port`

## Requirements
- R1: After reset every register holds 0x00, the selector is invalid, `mmio_base` is 0, and `io_rdata` is 0xFF.
- R2: A write to the selector address (0x22) latches `io_wdata` as the selector and marks it valid. A read of 0x22 returns the latched selector.
- R3: A data-address (0x23) access with no valid selector returns 0xFF on a read and changes nothing on a write.
- R4: Any read or write strobe on 0x23 invalidates the selector, so a second data access without a new selector write behaves as in R3.
- R5: The control register at selector 0xC3 can be read and written whatever its own unlock bit holds.
- R6: While bit 4 of the control register is 1, selectors 0xB0 to 0xBF reach sixteen extended registers that read back what was last written.
- R7: While bit 4 of the control register is 0, reads of selectors 0xB0 to 0xBF return 0xFF and writes to them leave the registers unchanged.
- R8: Selectors that are neither 0xC3 nor in 0xB0 to 0xBF read as 0xFF, and writes to them alter no register.
- R9: `mmio_base` equals bits [1:0] of extended register 0xB8 shifted left by 30. It follows a write to that register from the next clock edge.
- R10: `io_rdata` is 0xFF whenever `io_rd` is low. When `io_rd` and `io_wr` are both high, the write is performed and the read returns 0xFF.
- R11: Saving the control register, setting bit 4, accessing an extended register, and writing the saved value back leaves the extended group sealed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O address (0x22 selector, 0x23 data) |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| mmio_base | output | 32 | Base of the memory-mapped register window |

## Verification
Two things can happen in the same cycle: a data write that consumes the selector, and a read strobe on the same address. The bench raises `io_rd` and `io_wr` together on 0x23 and expects 0xFF on `io_rdata` in that cycle. It then re-selects the register and reads it, which shows that the write landed and that the selector was used up. A similar overlap happens when the control register is written in the same cycle as an extended access: the bench clears the unlock bit and then checks that the very next extended access is already sealed. Random traffic mixes both overlaps with ordinary accesses, and a reference model in the bench judges every returned byte.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic sel_wr;   // write to selector address
    logic sel_rd;   // read of selector address
    logic dat_wr;   // write to data address
    logic dat_rd;   // read of data address (no concurrent write)
    logic dat_any;  // any strobe on data address
  } io_acc_t;
endpackage

// File: rtl/cfg_index_latch.sv
module cfg_index_latch
  import cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_wr,
  input  byte_t wdata,
  input  logic  dat_any,
  output byte_t idx_q,
  output logic  idx_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      idx_valid <= 1'b0;
    end else if (sel_wr) begin
      idx_q     <= wdata;
      idx_valid <= 1'b1;
    end else if (dat_any) begin
      idx_valid <= 1'b0;
    end
  end

  assert_sel_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (idx_valid && idx_q == $past(wdata)));

  assert_sel_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_any && !sel_wr) |=> !idx_valid);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int EXT_COUNT = 16,
  localparam int SEL_W = $clog2(EXT_COUNT)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ctl,
  input  logic                   wr_ext,
  input  logic [SEL_W-1:0]       ext_sel,
  input  byte_t                  wdata,
  output byte_t                  ctl_q,
  output logic [EXT_COUNT*8-1:0] ext_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata;
  end

  for (genvar g = 0; g < EXT_COUNT; g++) begin : g_ext
    byte_t r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 r_q <= '0;
      else if (wr_ext && ext_sel == SEL_W'(g))    r_q <= wdata;
    end
    assign ext_flat[g*8 +: 8] = r_q;
  end
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
  import cfg_pkg::*;
#(
  parameter int    EXT_COUNT = 16,
  parameter byte_t EXT_FIRST = 8'hB0,
  parameter byte_t CTL_IDX   = 8'hC3,
  parameter int    UNLOCK_BIT = 4,
  localparam int   SEL_W = $clog2(EXT_COUNT)
)(
  input  io_acc_t                acc,
  input  byte_t                  idx_q,
  input  logic                   idx_valid,
  input  byte_t                  ctl_q,
  input  logic [EXT_COUNT*8-1:0] ext_flat,
  output logic                   wr_ctl,
  output logic                   wr_ext,
  output logic [SEL_W-1:0]       ext_sel,
  output byte_t                  rdata
);
  byte_t offs;
  logic  in_ext, hit_ctl, hit_ext, unlocked;

  always_comb begin
    offs     = idx_q - EXT_FIRST;
    in_ext   = (int'(idx_q) >= int'(EXT_FIRST)) &&
               (int'(idx_q) <  int'(EXT_FIRST) + EXT_COUNT);
    unlocked = ctl_q[UNLOCK_BIT];
    hit_ctl  = idx_valid && (idx_q == CTL_IDX);
    hit_ext  = idx_valid && in_ext && unlocked;
    ext_sel  = offs[SEL_W-1:0];
    wr_ctl   = acc.dat_wr && hit_ctl;
    wr_ext   = acc.dat_wr && hit_ext;

    rdata = 8'hFF;
    if (acc.sel_rd) rdata = idx_q;
    else if (acc.dat_rd) begin
      if (hit_ctl)      rdata = ctl_q;
      else if (hit_ext) rdata = ext_flat[ext_sel*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_pkg::*;
#(
  parameter byte_t SEL_PORT   = 8'h22,
  parameter byte_t DAT_PORT   = 8'h23,
  parameter byte_t CTL_IDX    = 8'hC3,
  parameter int    UNLOCK_BIT = 4,
  parameter byte_t EXT_FIRST  = 8'hB0,
  parameter int    EXT_COUNT  = 16,
  parameter byte_t BASE_IDX   = 8'hB8,
  parameter int    BASE_W     = 32,
  localparam int   SEL_W      = $clog2(EXT_COUNT),
  localparam int   BASE_SLOT  = int'(BASE_IDX) - int'(EXT_FIRST)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [BASE_W-1:0] mmio_base
);
  io_acc_t                acc;
  byte_t                  idx_q, ctl_q;
  logic                   idx_valid, wr_ctl, wr_ext;
  logic [SEL_W-1:0]       ext_sel;
  logic [EXT_COUNT*8-1:0] ext_flat;

  always_comb begin
    acc.sel_wr  = io_wr && (io_addr == SEL_PORT);
    acc.sel_rd  = io_rd && !io_wr && (io_addr == SEL_PORT);
    acc.dat_wr  = io_wr && (io_addr == DAT_PORT);
    acc.dat_rd  = io_rd && !io_wr && (io_addr == DAT_PORT);
    acc.dat_any = (io_wr || io_rd) && (io_addr == DAT_PORT);
  end

  cfg_index_latch u_latch (
    .clk(clk), .rst_n(rst_n), .sel_wr(acc.sel_wr), .wdata(io_wdata),
    .dat_any(acc.dat_any), .idx_q(idx_q), .idx_valid(idx_valid)
  );

  cfg_access_gate #(.EXT_COUNT(EXT_COUNT), .EXT_FIRST(EXT_FIRST),
                    .CTL_IDX(CTL_IDX), .UNLOCK_BIT(UNLOCK_BIT)) u_gate (
    .acc(acc), .idx_q(idx_q), .idx_valid(idx_valid), .ctl_q(ctl_q),
    .ext_flat(ext_flat), .wr_ctl(wr_ctl), .wr_ext(wr_ext),
    .ext_sel(ext_sel), .rdata(io_rdata)
  );

  cfg_reg_bank #(.EXT_COUNT(EXT_COUNT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_ext(wr_ext),
    .ext_sel(ext_sel), .wdata(io_wdata), .ctl_q(ctl_q), .ext_flat(ext_flat)
  );

  assign mmio_base = {ext_flat[BASE_SLOT*8 +: 2], {(BASE_W-2){1'b0}}};

  // Checks built from port-level decode, independent of the gate
  logic in_ext_chk, base_wr_chk;
  assign in_ext_chk  = (int'(idx_q) >= int'(EXT_FIRST)) &&
                       (int'(idx_q) < int'(EXT_FIRST) + EXT_COUNT);
  assign base_wr_chk = io_wr && io_addr == DAT_PORT && idx_valid &&
                       idx_q == BASE_IDX && ctl_q[UNLOCK_BIT];

  assert_sealed_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == DAT_PORT && idx_valid && in_ext_chk && !ctl_q[UNLOCK_BIT])
      |=> $stable(ext_flat));

  assert_base_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_chk |=> (mmio_base[BASE_W-1 -: 2] == $past(io_wdata[1:0])));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || io_wr) |-> (io_rdata == 8'hFF));
endmodule

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [31:0] mmio_base;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  cfg_index_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mmio_base(mmio_base)
  );

  // reference model
  logic [7:0] m_ctl;
  logic [7:0] m_ext [16];
  logic [7:0] m_idx;
  bit         m_val;

  function automatic bit is_ext(input logic [7:0] i);
    return (i >= 8'hB0) && (i <= 8'hBF);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a, input bit w, input bit r);
    if (!r || w) return 8'hFF;
    if (a == 8'h22) return m_idx;
    if (a != 8'h23 || !m_val) return 8'hFF;
    if (m_idx == 8'hC3) return m_ctl;
    if (is_ext(m_idx) && m_ctl[4]) return m_ext[m_idx - 8'hB0];
    return 8'hFF;
  endfunction

  function automatic string tag_of(input logic [7:0] a, input bit w, input bit r);
    if (w && r) return "R10";
    if (!r && !w) return "R10";
    if (a == 8'h22) return "R2";
    if (a != 8'h23) return "R10";
    if (!m_val) return "R3";
    if (m_idx == 8'hC3) return "R5";
    if (is_ext(m_idx)) return m_ctl[4] ? "R6" : "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input bit w, input bit r,
                       input logic [7:0] d, input string tag);
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #1;
    check(tag, {24'h0, io_rdata}, {24'h0, exp_rd(a, w, r)});
    if (w && a == 8'h22) begin m_idx = d; m_val = 1; end
    else if (a == 8'h23 && (w || r)) begin
      if (w && m_val) begin
        if (m_idx == 8'hC3) m_ctl = d;
        else if (is_ext(m_idx) && m_ctl[4]) m_ext[m_idx - 8'hB0] = d;
      end
      m_val = 0;
    end
    @(posedge clk); #1;
    io_wr = 0; io_rd = 0;
    if (w) check("R9", mmio_base, {m_ext[8][1:0], 30'b0});
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d, input string tag);
    apply(8'h22, 1, 0, i, "R2");
    apply(8'h23, 1, 0, d, tag);
  endtask

  task automatic reg_rd(input logic [7:0] i, input string tag);
    apply(8'h22, 1, 0, i, "R2");
    apply(8'h23, 0, 1, 8'h00, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] saved;
    void'($urandom(32'd1234));
    m_ctl = 0; m_idx = 0; m_val = 0;
    for (int i = 0; i < 16; i++) m_ext[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", {24'h0, io_rdata}, 32'hFF);
    check("R1", mmio_base, 32'h0);
    apply(8'h23, 0, 1, 0, "R1");          // selector invalid after reset
    apply(8'h22, 0, 1, 0, "R1");          // selector reads zero
    reg_rd(8'hC3, "R1");
    apply(8'h22, 1, 0, 8'h5A, "R2");
    apply(8'h22, 0, 1, 0, "R2");
    apply(8'h23, 1, 0, 8'h99, "R3");      // consumes selector 0x5A
    apply(8'h23, 1, 0, 8'h44, "R3");      // no selector: dropped
    reg_wr(8'hC3, 8'h21, "R5");
    reg_rd(8'hC3, "R5");
    apply(8'h23, 0, 1, 0, "R4");          // second read without reselect
    reg_wr(8'hB2, 8'h77, "R7");           // sealed: dropped
    reg_rd(8'hB2, "R7");
    reg_wr(8'hC3, 8'h31, "R5");           // unlock
    reg_rd(8'hB2, "R7");                  // expects 00: earlier write dropped
    reg_wr(8'hB2, 8'h77, "R6");
    reg_rd(8'hB2, "R6");
    reg_wr(8'hBF, 8'hE1, "R6");
    reg_rd(8'hBF, "R6");
    reg_wr(8'hB8, 8'h03, "R9");
    reg_wr(8'hB8, 8'hFE, "R9");
    reg_wr(8'h10, 8'hAA, "R8");
    reg_rd(8'h10, "R8");
    reg_rd(8'hAF, "R8");
    apply(8'h22, 1, 0, 8'hB3, "R2");
    apply(8'h23, 1, 1, 8'h5C, "R10");     // write wins, read shows FF
    apply(8'h23, 0, 1, 0, "R10");         // selector consumed
    reg_rd(8'hB3, "R10");
    // save / set / access / restore
    reg_wr(8'hC3, 8'h21, "R11");
    reg_rd(8'hC3, "R11");
    saved = m_ctl;
    reg_wr(8'hC3, saved | 8'h10, "R11");
    reg_wr(8'hB5, 8'h6D, "R11");
    reg_rd(8'hB5, "R11");
    reg_wr(8'hC3, saved, "R11");
    reg_rd(8'hB5, "R11");                 // sealed again: FF
    reg_wr(8'hB5, 8'h00, "R11");
    reg_wr(8'hC3, 8'h10, "R11");
    reg_rd(8'hB5, "R11");                 // still 6D
    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a, d;
      bit w, r;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? 8'h22 : (pick < 9) ? 8'h23 : 8'($urandom_range(0, 255));
      w = $urandom_range(0, 1) == 1;
      r = $urandom_range(0, 3) != 0;
      if (a == 8'h22 && w) begin
        pick = $urandom_range(0, 9);
        d = (pick < 3) ? 8'hC3 : (pick < 8) ? 8'(8'hB0 + $urandom_range(0, 15))
                                          : 8'($urandom_range(0, 255));
      end else d = 8'($urandom_range(0, 255));
      apply(a, w, r, d, tag_of(a, w, r));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule